// File: doc/BRIEF.md
# Synchronous Clock Divider Bank

This block takes a single input clock and produces two groups of divided clocks whose shared edges coincide exactly: a fast group and a slow group, each with several identical copies and a complement for every copy. Every divider stage advances on the rising input edge, so any edge the two groups have in common falls on the same input edge.

A family input picks one of two ratio families. In the coarse family the fast group runs at half the input rate and the slow group at one quarter or one sixth. In the fine family the fast group carries the input clock itself, gated, and the slow group runs at one half or one third. A ratio input picks the slow group's ratio within the family. A hold request stops every output at its present level and releases it again. The request is captured on the falling input edge, so it only acts while the clock is low and the gated full-rate output can never show a shortened pulse. An asynchronous master clear puts every stage into a known phase. This lets several copies of the block start in lockstep.

Top module: `dvb_divider_bank`

## Requirements
- R1: With `fine_mode`=0 every `fast_q` bit divides `clk_in` by 2 at 50% duty. It goes high on the first rising edge after clear and then toggles on each rising edge.
- R2: With `fine_mode`=0 every `slow_q` bit divides by 4 when `ratio_big`=0 and by 6 when `ratio_big`=1, at 50% duty. It is high for the first 2 (or 3) input periods after clear.
- R3: With `fine_mode`=1 every `fast_q` bit equals `clk_in` gated by the captured hold: high while the clock is high and not held, low otherwise.
- R4: With `fine_mode`=1 every `slow_q` bit divides by 2 when `ratio_big`=0 and by 3 when `ratio_big`=1. The divide-by-3 waveform is high for one input period and low for two.
- R5: Every rising edge of a slow output coincides with a rising edge of the fast output. Both rise on the first rising input edge after clear is released.
- R6: `hold_req`=1 is captured on a falling `clk_in` edge. From the next rising edge, all outputs keep their levels. Rising edges after a falling edge that captured 0 resume the count where it stopped.
- R7: A change of `hold_req` while `clk_in` is high has no effect on any output until the next falling edge. In particular it does not cut short a high pulse of the full-rate output.
- R8: `sync_clr`=1 acts at once, regardless of the clock. It drives every `fast_q`/`slow_q` bit low and every complement high, and it clears the captured hold so the first rising edge after release always counts.
- R9: All copies in a group carry the same level, and each `_qn` bit is the inverse of its `_q` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| sync_clr | input | 1 | Asynchronous master clear, active high |
| hold_req | input | 1 | Hold request, 1 = freeze outputs; captured on falling edge |
| fine_mode | input | 1 | Ratio family: 0 = coarse (2; 4/6), 1 = fine (1; 2/3) |
| ratio_big | input | 1 | Slow ratio within family: 0 = smaller, 1 = larger |
| fast_q | output | FAST_COPIES | Fast group outputs |
| fast_qn | output | FAST_COPIES | Complements of fast_q |
| slow_q | output | SLOW_COPIES | Slow group outputs |
| slow_qn | output | SLOW_COPIES | Complements of slow_q |

## Verification
A phase counter left in the wrong state shows up at the ports within one slow period. The slow output rises at a point that is not on a rising fast edge, or its high time has the wrong length, so sampling both groups in the high and low halves of every input period exposes it within at most six cycles. A hold flop that samples on the wrong edge shows up in the first period after the request changes: either the full-rate output loses part of a high phase, or the dividers take one step too many or too few before freezing. A clear that is not asynchronous leaves a high level visible in the same half-period in which clear rises.

// File: rtl/dvb_pkg.sv
`timescale 1ns/1ps
// Package dvb_pkg
// Shared constants and the ratio decode for the divider bank.
// Assumes ratios fit in CNT_W bits and that the largest ratio is even or 3.
package dvb_pkg;
    localparam int CNT_W            = 3;
    localparam int FAST_RATIO       = 2;
    localparam int COARSE_SMALL     = 4;
    localparam int COARSE_LARGE     = 6;
    localparam int FINE_SMALL       = 2;
    localparam int FINE_LARGE       = 3;

    // Decode the slow group ratio from family and ratio selects.
    function automatic logic [CNT_W-1:0] slow_ratio(input logic fine, input logic big);
        logic [CNT_W-1:0] r;
        case ({fine, big})
            2'b00:   r = CNT_W'(COARSE_SMALL);
            2'b01:   r = CNT_W'(COARSE_LARGE);
            2'b10:   r = CNT_W'(FINE_SMALL);
            default: r = CNT_W'(FINE_LARGE);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dvb_hold_sync.sv
`timescale 1ns/1ps
// Module dvb_hold_sync
// Captures the hold request on the falling clock edge, so that the captured
// value only changes while the clock is low. Asynchronous clear forces the
// captured value to 0 (run).
// Assumes hold_req is stable around the falling edge.
module dvb_hold_sync (
    input  logic clk_in,
    input  logic clr,
    input  logic hold_req,
    output logic hold_q
);
    // Falling-edge capture of the hold request.
    always_ff @(negedge clk_in or posedge clr) begin
        if (clr) hold_q <= 1'b0;
        else     hold_q <= hold_req;
    end

    // R6: captured value follows the request sampled at the previous falling edge
    a_r6_capture_on_fall: assert property (@(negedge clk_in) disable iff (clr)
        1'b1 |=> (hold_q == $past(hold_req)));
endmodule

// File: rtl/dvb_phase_div.sv
`timescale 1ns/1ps
// Module dvb_phase_div
// Runtime-ratio divider. A phase count runs 1..ratio, and the output is high
// for the first ratio/2 phases (floor). That gives 50% duty for even ratios
// and one-period-high for ratio 3. After clear the phase is 0 and the first
// advancing edge starts a new period with the output rising.
// Assumes ratio >= 2 and is held constant between clears.
module dvb_phase_div #(
    parameter int CNT_W = 3
) (
    input  logic             clk_in,
    input  logic             clr,
    input  logic             advance,
    input  logic [CNT_W-1:0] ratio,
    output logic             lvl
);
    logic [CNT_W-1:0] ph;
    logic [CNT_W-1:0] ph_nxt;
    logic [CNT_W-1:0] high_len;

    // Next phase: wrap to 1 at end of period or after clear.
    always_comb begin
        high_len = ratio >> 1;
        if (ph == '0 || ph >= ratio) ph_nxt = CNT_W'(1);
        else                         ph_nxt = ph + CNT_W'(1);
    end

    // Phase and output registers, advancing only when not held.
    always_ff @(posedge clk_in or posedge clr) begin
        if (clr) begin
            ph  <= '0;
            lvl <= 1'b0;
        end else if (advance) begin
            ph  <= ph_nxt;
            lvl <= (ph_nxt <= high_len);
        end
    end

    // R6: a held edge leaves the output level unchanged
    a_r6_freeze_level: assert property (@(posedge clk_in) disable iff (clr)
        !advance |=> $stable(lvl));
    // R2: phase never runs past the selected ratio
    a_r2_phase_bound: assert property (@(posedge clk_in) disable iff (clr)
        ph <= ratio);
    // R5: a period start drives the output high
    a_r5_wrap_rises: assert property (@(posedge clk_in) disable iff (clr)
        (advance && (ph == '0 || ph >= ratio)) |=> lvl);
endmodule

// File: rtl/dvb_out_drv.sv
`timescale 1ns/1ps
// Module dvb_out_drv
// Fans one level out to COPIES true outputs and their complements.
// Assumes nothing beyond COPIES >= 1.
module dvb_out_drv #(
    parameter int COPIES = 2
) (
    input  logic              lvl,
    output logic [COPIES-1:0] q,
    output logic [COPIES-1:0] qn
);
    // One true/complement pair per copy.
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        assign q[i]  = lvl;
        assign qn[i] = ~lvl;
    end
endmodule

// File: rtl/dvb_divider_bank.sv
`timescale 1ns/1ps
// Module dvb_divider_bank
// Top of the divider bank: falling-edge hold capture, a fixed divide-by-2
// and a selectable slow divider on one rising edge, the full-rate gated
// path, and output fan-out with complements.
// Assumes fine_mode and ratio_big change only while sync_clr is high.
module dvb_divider_bank #(
    parameter int FAST_COPIES = 2,
    parameter int SLOW_COPIES = 2
) (
    input  logic                   clk_in,
    input  logic                   sync_clr,
    input  logic                   hold_req,
    input  logic                   fine_mode,
    input  logic                   ratio_big,
    output logic [FAST_COPIES-1:0] fast_q,
    output logic [FAST_COPIES-1:0] fast_qn,
    output logic [SLOW_COPIES-1:0] slow_q,
    output logic [SLOW_COPIES-1:0] slow_qn
);
    import dvb_pkg::*;

    localparam logic [CNT_W-1:0] FAST_R = CNT_W'(FAST_RATIO);

    logic             hold_q;
    logic             run;
    logic             fast_div_lvl;
    logic             slow_lvl;
    logic             fast_lvl;
    logic [CNT_W-1:0] slow_r;

    // Slow ratio selected by the two mode inputs.
    always_comb slow_r = slow_ratio(fine_mode, ratio_big);

    // Dividers advance only when the captured hold is clear.
    always_comb run = ~hold_q;

    dvb_hold_sync u_hold (
        .clk_in   (clk_in),
        .clr      (sync_clr),
        .hold_req (hold_req),
        .hold_q   (hold_q)
    );

    dvb_phase_div #(.CNT_W(CNT_W)) u_fast_div (
        .clk_in  (clk_in),
        .clr     (sync_clr),
        .advance (run),
        .ratio   (FAST_R),
        .lvl     (fast_div_lvl)
    );

    dvb_phase_div #(.CNT_W(CNT_W)) u_slow_div (
        .clk_in  (clk_in),
        .clr     (sync_clr),
        .advance (run),
        .ratio   (slow_r),
        .lvl     (slow_lvl)
    );

    // Fast level: gated input clock in the fine family, divide-by-2 otherwise.
    always_comb fast_lvl = fine_mode ? (clk_in & run & ~sync_clr) : fast_div_lvl;

    dvb_out_drv #(.COPIES(FAST_COPIES)) u_fast_out (
        .lvl (fast_lvl),
        .q   (fast_q),
        .qn  (fast_qn)
    );

    dvb_out_drv #(.COPIES(SLOW_COPIES)) u_slow_out (
        .lvl (slow_lvl),
        .q   (slow_q),
        .qn  (slow_qn)
    );

    // R5: in the coarse family a slow rise comes with a fast rise
    a_r5_rise_aligned: assert property (@(posedge clk_in) disable iff (sync_clr)
        (!fine_mode && $rose(slow_lvl)) |-> $rose(fast_div_lvl));
    // R4: divide-by-3 output is high for exactly one input period
    a_r4_odd_pulse: assert property (@(posedge clk_in) disable iff (sync_clr)
        (fine_mode && ratio_big && slow_lvl && !hold_q) |=> !slow_lvl);
    // R8: while clear is high, all levels and the captured hold are low
    a_r8_clear_low: assert property (@(posedge clk_in)
        sync_clr |-> (!fast_lvl && !slow_lvl && !hold_q));
endmodule

// File: tb/dvb_divider_bank_test.sv
`timescale 1ns/1ps
module dvb_divider_bank_test;
    localparam int NF = 2;
    localparam int NS = 2;
    localparam int NCYC = 12;

    logic          clk = 1'b0;
    logic          sync_clr = 1'b1;
    logic          hold_req = 1'b0;
    logic          fine_mode = 1'b0;
    logic          ratio_big = 1'b0;
    logic [NF-1:0] fast_q, fast_qn;
    logic [NS-1:0] slow_q, slow_qn;

    integer checks = 0;
    integer errors = 0;
    bit     done = 1'b0;

    always #2.5 clk = ~clk;

    dvb_divider_bank #(.FAST_COPIES(NF), .SLOW_COPIES(NS)) uut (
        .clk_in   (clk),
        .sync_clr (sync_clr),
        .hold_req (hold_req),
        .fine_mode(fine_mode),
        .ratio_big(ratio_big),
        .fast_q   (fast_q),
        .fast_qn  (fast_qn),
        .slow_q   (slow_q),
        .slow_qn  (slow_qn)
    );

    // {fine_mode, ratio_big, fast_is_clock, fast pattern, slow pattern};
    // pattern MSB is the level after the first rising edge after clear.
    localparam logic [26:0] VECS [0:3] = '{
        {1'b0, 1'b0, 1'b0, 12'b101010101010, 12'b110011001100},
        {1'b0, 1'b1, 1'b0, 12'b101010101010, 12'b111000111000},
        {1'b1, 1'b0, 1'b1, 12'b111111111111, 12'b101010101010},
        {1'b1, 1'b1, 1'b1, 12'b111111111111, 12'b100100100100}
    };

    task automatic check(input string tag, input logic ef, input logic es);
        logic [NF-1:0] xf;
        logic [NS-1:0] xs;
        xf = {NF{ef}};
        xs = {NS{es}};
        checks++;
        if (fast_q !== xf || fast_qn !== ~xf || slow_q !== xs || slow_qn !== ~xs) begin
            errors++;
            $display("FAIL %s R9 t=%0t: fast_q=%b fast_qn=%b slow_q=%b slow_qn=%b expected fast_q=%b slow_q=%b",
                     tag, $time, fast_q, fast_qn, slow_q, slow_qn, xf, xs);
        end
    endtask

    // Clear, set modes, check the cleared state, release in the low phase.
    task automatic clear_and_start(input logic fm, input logic rb, input logic hr);
        @(negedge clk); #1;
        sync_clr = 1'b1;
        fine_mode = fm;
        ratio_big = rb;
        repeat (2) @(negedge clk);
        #1;
        check("R8 cleared state", 1'b0, 1'b0);
        hold_req = hr;
        sync_clr = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Table walk: R1 R2 R3 R4 R5 over all four ratio settings
        for (int v = 0; v < 4; v++) begin
            logic [26:0] e;
            e = VECS[v];
            clear_and_start(e[26], e[25], 1'b0);
            for (int k = 0; k < NCYC; k++) begin
                @(posedge clk); #1;
                check(e[26] ? "R3 R4 R5 high phase" : "R1 R2 R5 high phase",
                      e[23 - k], e[11 - k]);
                @(negedge clk); #1;
                check(e[26] ? "R3 R4 low phase" : "R1 R2 low phase",
                      e[24] ? 1'b0 : e[23 - k], e[11 - k]);
            end
        end

        // R6: hold in coarse family, divide by 4
        clear_and_start(1'b0, 1'b0, 1'b0);
        @(posedge clk); #1; check("R6 run c1", 1'b1, 1'b1);
        @(posedge clk); #1; check("R6 run c2", 1'b0, 1'b1);
        @(negedge clk); #1; hold_req = 1'b1;
        @(posedge clk); #1; check("R6 last edge before capture", 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1; check("R6 frozen high phase", 1'b1, 1'b0);
        @(negedge clk); #1; check("R6 frozen low phase", 1'b1, 1'b0);
        hold_req = 1'b0;
        @(posedge clk); #1; check("R6 still frozen before capture", 1'b1, 1'b0);
        @(posedge clk); #1; check("R6 resumed c4", 1'b0, 1'b0);
        @(posedge clk); #1; check("R6 resumed c5", 1'b1, 1'b1);

        // R7: hold changes during the high phase, fine family divide by 2
        clear_and_start(1'b1, 1'b0, 1'b0);
        @(posedge clk); #1; check("R7 run c1", 1'b1, 1'b1);
        hold_req = 1'b1;
        #0.5; check("R7 no cut of high pulse", 1'b1, 1'b1);
        @(posedge clk); #1; check("R7 held after fall", 1'b0, 1'b1);
        @(posedge clk); #1; check("R7 held again", 1'b0, 1'b1);
        hold_req = 1'b0;
        #0.5; check("R7 release waits for fall", 1'b0, 1'b1);
        @(posedge clk); #1; check("R7 resumed", 1'b1, 1'b0);

        // R8: asynchronous clear in the high phase, fine family divide by 3
        clear_and_start(1'b1, 1'b1, 1'b0);
        @(posedge clk); #1; check("R8 pre-clear", 1'b1, 1'b1);
        #0.5; sync_clr = 1'b1;
        #0.3; check("R8 immediate clear", 1'b0, 1'b0);

        // R8: clear drops the captured hold; first edge counts even with hold_req=1
        clear_and_start(1'b0, 1'b0, 1'b1);
        @(posedge clk); #1; check("R8 hold cleared, first edge counts", 1'b1, 1'b1);
        @(posedge clk); #1; check("R6 R8 hold takes effect after fall", 1'b1, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule